// File: doc/BRIEF.md
# Write-Back Invalidate Coherence Controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared atomic bus. Each line is invalid, shared or exclusive. Shared means clean and read-only. Exclusive means this cache holds the only copy, and that copy is dirty and writable. The processor side uses a hold-until-acknowledge handshake: the request is held until a one-cycle acknowledge returns the read data or confirms the write. Hits that need no coherence action finish locally in one cycle. Every other access raises a bus request. After grant, the controller writes back a dirty victim if there is one, then issues a read miss or a write miss.

The controller also watches the commands other caches place on the bus. A write miss from another cache that matches a shared line invalidates that line. A read miss or write miss that matches an exclusive line makes this cache take over the reply: it supplies its data and asserts an abort that stops memory from answering. The line then falls to shared after a read miss, or to invalid after a write miss. Snoops take priority over the processor for the line array. A line is never changed for a processor miss before the grant arrives. If a snoop alters the pending line while the controller waits for the grant, the miss is re-evaluated from the new state.

Addresses are block addresses. The low bits select the line and the rest form the tag. A block is one data word. Snoops arrive only while this controller does not hold the bus.

Top module: `wbi_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first read of any address issues a read miss.
- R2: A read that misses issues bus_cmd 01 (read miss) with the requested address while granted. It returns bus_rdata sampled in that cycle, and the line becomes shared.
- R3: A read that hits a shared or exclusive line acknowledges one cycle after the request is seen and places nothing on the bus. cpu_ack is a single-cycle pulse.
- R4: A write to a line that is invalid or shared, whether the tag matches or not, issues bus_cmd 10 (write miss) and leaves the line exclusive, holding the written data.
- R5: A read or write that hits an exclusive line completes in one cycle with no bus transaction.
- R6: A miss whose line is exclusive with another tag first issues bus_cmd 11 (write-back) carrying the old address and data. The miss follows in the very next cycle of the same grant.
- R7: A read miss whose line is shared with another tag replaces the line with a read miss only, with no write-back, and the line stays shared.
- R8: A snooped write miss (snp_cmd 10) that hits a shared line invalidates it without asserting abort.
- R9: A snooped read miss (snp_cmd 01) that hits an exclusive line asserts snp_abort with the line data on snp_data in the same cycle, and leaves the line shared. A snoop that misses or hits a shared line on a read miss asserts no abort.
- R10: A snooped write miss that hits an exclusive line asserts snp_abort with the line data and leaves the line invalid.
- R11: While a miss waits for grant, a snoop to the pending line is applied first, and the bus sequence after grant follows the line's new state. No line is filled without grant.
- R12: bus_valid is asserted only while bus_gnt is high, and bus_req stays high from the first cycle of a miss until its last bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | A transaction is driven this cycle |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction block address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data for a miss, same cycle |
| snp_valid | input | 1 | Another agent's command is on the bus |
| snp_cmd | input | 2 | 01 read miss, 10 write miss |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_abort | output | 1 | This cache supplies data; memory must not reply |
| snp_data | output | DATA_W | Supplied block data |

## Verification
A line left in the wrong state shows at the ports on the next access to that line. A stale shared line answers a read in one cycle with no bus traffic, where a read miss was due. A line that missed an invalidation or a downgrade either skips the write miss on the next store or fails to raise abort on the next snoop. A lost dirty flag shows up at the next conflicting miss as a missing write-back, or as a write-back carrying the wrong data. The bench therefore follows every state change with a probe that exposes it within a few cycles. It compares the ordered bus transactions against an expected queue, and an unexpected transaction is flagged at once.

// File: rtl/wbi_pkg.sv
package wbi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_t;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ARB,
    CS_WB,
    CS_MISS,
    CS_DONE
  } ctl_st_t;
endpackage

// File: rtl/wbi_line_store.sv
module wbi_line_store
  import wbi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic              s_we,
  input  line_st_t          s_state,
  input  logic              c_we,
  input  line_st_t          c_state,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data,
  output line_st_t          cpu_st,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  output line_st_t          snp_st,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_a  [LINES];
  logic [TAG_W-1:0]  tag_a [LINES];
  logic [DATA_W-1:0] dat_a [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    line_st_t          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              s_hit_w, c_hit_w;

    assign s_hit_w = s_we && (snp_idx == MY_IDX);
    assign c_hit_w = c_we && (cpu_idx == MY_IDX);

    // snoop update wins over processor update on the same line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_r <= LN_INV;
      else if (s_hit_w) st_r <= s_state;
      else if (c_hit_w) st_r <= c_state;
    end

    always_ff @(posedge clk) begin
      if (c_hit_w) begin
        tag_r <= c_tag;
        dat_r <= c_data;
      end
    end

    assign st_a[i]  = st_r;
    assign tag_a[i] = tag_r;
    assign dat_a[i] = dat_r;
  end

  assign cpu_st   = st_a[cpu_idx];
  assign cpu_tag  = tag_a[cpu_idx];
  assign cpu_data = dat_a[cpu_idx];
  assign snp_st   = st_a[snp_idx];
  assign snp_tag  = tag_a[snp_idx];
  assign snp_data = dat_a[snp_idx];
endmodule

// File: rtl/wbi_snoop_unit.sv
module wbi_snoop_unit
  import wbi_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_we,
  output line_st_t          upd_state,
  output logic              abort,
  output logic [DATA_W-1:0] supply
);
  logic hit, is_rd, is_wr;

  assign hit   = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);
  assign is_rd = (snp_cmd == BC_RDMISS);
  assign is_wr = (snp_cmd == BC_WRMISS);

  always_comb begin
    upd_we    = 1'b0;
    upd_state = LN_INV;
    abort     = 1'b0;
    if (hit && (line_st == LN_EXC) && (is_rd || is_wr)) begin
      abort     = 1'b1;
      upd_we    = 1'b1;
      upd_state = is_rd ? LN_SHR : LN_INV;
    end else if (hit && (line_st == LN_SHR) && is_wr) begin
      upd_we    = 1'b1;
      upd_state = LN_INV;
    end
  end

  assign supply = abort ? line_data : '0;

  // R9/R10: a downgrade that drops exclusivity must come with an abort
  assert_abort_with_downgrade_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && line_st == LN_EXC) |-> (abort && snp_valid));
endmodule

// File: rtl/wbi_coherence_ctrl.sv
module wbi_coherence_ctrl
  import wbi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_t           ctl_q, ctl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag_req, s_tag_req;
  line_st_t          cpu_st, snp_st, s_state, c_state;
  logic [TAG_W-1:0]  cpu_ltag, snp_ltag;
  logic [DATA_W-1:0] cpu_ldata, snp_ldata, c_data;
  logic              s_we, c_we, cpu_hit;
  bus_cmd_t          cmd_d;

  assign c_idx     = cpu_addr[IDX_W-1:0];
  assign c_tag_req = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx     = snp_addr[IDX_W-1:0];
  assign s_tag_req = snp_addr[ADDR_W-1:IDX_W];

  wbi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(c_idx), .snp_idx(s_idx),
    .s_we(s_we), .s_state(s_state),
    .c_we(c_we), .c_state(c_state), .c_tag(c_tag_req), .c_data(c_data),
    .cpu_st(cpu_st), .cpu_tag(cpu_ltag), .cpu_data(cpu_ldata),
    .snp_st(snp_st), .snp_tag(snp_ltag), .snp_data(snp_ldata)
  );

  wbi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tag_req),
    .line_st(snp_st), .line_tag(snp_ltag), .line_data(snp_ldata),
    .upd_we(s_we), .upd_state(s_state),
    .abort(snp_abort), .supply(snp_data)
  );

  assign cpu_hit = (cpu_st != LN_INV) && (cpu_ltag == c_tag_req);

  always_comb begin
    ctl_d     = ctl_q;
    rdata_en  = 1'b0;
    rdata_d   = rdata_q;
    c_we      = 1'b0;
    c_state   = LN_INV;
    c_data    = cpu_wdata;
    cmd_d     = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (ctl_q)
      CS_IDLE: begin
        // a snoop in the same cycle owns the line array
        if (cpu_req && !snp_valid) begin
          if (!cpu_we && cpu_hit) begin
            rdata_en = 1'b1;
            rdata_d  = cpu_ldata;
            ctl_d    = CS_DONE;
          end else if (cpu_we && cpu_hit && cpu_st == LN_EXC) begin
            c_we    = 1'b1;
            c_state = LN_EXC;
            ctl_d   = CS_DONE;
          end else begin
            ctl_d = CS_ARB;
          end
        end
      end
      CS_ARB: begin
        // state re-read here so that snoops seen while waiting take effect
        if (bus_gnt) begin
          if (cpu_st == LN_EXC && cpu_ltag != c_tag_req) ctl_d = CS_WB;
          else                                            ctl_d = CS_MISS;
        end
      end
      CS_WB: begin
        cmd_d     = BC_WBACK;
        bus_addr  = {cpu_ltag, c_idx};
        bus_wdata = cpu_ldata;
        ctl_d     = CS_MISS;
      end
      CS_MISS: begin
        cmd_d    = cpu_we ? BC_WRMISS : BC_RDMISS;
        bus_addr = cpu_addr;
        c_we     = 1'b1;
        c_state  = cpu_we ? LN_EXC : LN_SHR;
        c_data   = cpu_we ? cpu_wdata : bus_rdata;
        rdata_en = 1'b1;
        rdata_d  = bus_rdata;
        ctl_d    = CS_DONE;
      end
      CS_DONE: ctl_d = CS_IDLE;
      default: ctl_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CS_IDLE;
    else        ctl_q <= ctl_d;
  end

  always_ff @(posedge clk) begin
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_ack   = (ctl_q == CS_DONE);
  assign cpu_rdata = rdata_q;
  assign bus_req   = (ctl_q == CS_ARB) || (ctl_q == CS_WB) || (ctl_q == CS_MISS);
  assign bus_valid = (cmd_d != BC_NONE);
  assign bus_cmd   = cmd_d;

  assert_bus_granted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_gnt && bus_req));

  assert_wb_then_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_WBACK) |=>
      (bus_valid && (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS)));

  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  assert_fill_needs_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> (bus_gnt || (cpu_we && cpu_st == LN_EXC && !bus_req)));
endmodule

// File: tb/sim_wbi_coherence_ctrl.sv
module sim_wbi_coherence_ctrl;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we, cpu_ack;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic bus_req, bus_gnt, bus_valid;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic snp_valid, snp_abort;
  logic [1:0] snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;
  logic gnt_block;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [1:0]    q_cmd [$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_dat [$];
  string         q_tag [$];

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  assign bus_rdata = mem_of(bus_addr);

  wbi_coherence_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_abort(snp_abort), .snp_data(snp_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_bus(input logic [1:0] c, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string tag);
    q_cmd.push_back(c); q_addr.push_back(a); q_dat.push_back(d); q_tag.push_back(tag);
  endtask

  // arbiter: grant follows request unless held off
  always @(negedge clk) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !gnt_block;
  end

  // monitor: compare each bus transaction with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      chk(bus_gnt, "R12 valid without grant", int'(bus_gnt), 1);
      if (q_cmd.size() == 0) begin
        chk(1'b0, "unexpected bus transaction", int'({bus_cmd, bus_addr}), 0);
      end else begin
        logic [1:0] ec; logic [AW-1:0] ea; logic [DW-1:0] ed; string et;
        ec = q_cmd.pop_front(); ea = q_addr.pop_front();
        ed = q_dat.pop_front(); et = q_tag.pop_front();
        chk(bus_cmd == ec && bus_addr == ea, {et, " bus cmd/addr"},
            int'({bus_cmd, bus_addr}), int'({ec, ea}));
        if (ec == 2'b11) chk(bus_wdata == ed, {et, " write-back data"}, bus_wdata, ed);
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit chk_rd, input logic [DW-1:0] exp_rd,
                        input int exp_lat, input string tag);
    int n;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_ack && n < 100);
    chk(cpu_ack, {tag, " ack"}, int'(cpu_ack), 1);
    if (exp_lat != 0) chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
    if (chk_rd) chk(cpu_rdata == exp_rd, {tag, " read data"}, cpu_rdata, exp_rd);
    chk(q_cmd.size() == 0, {tag, " missing bus transaction"}, q_cmd.size(), 0);
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input bit exp_ab,
                       input logic [DW-1:0] exp_d, input string tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #2;
    chk(snp_abort == exp_ab, {tag, " abort"}, int'(snp_abort), int'(exp_ab));
    if (exp_ab) chk(snp_data == exp_d, {tag, " supplied data"}, snp_data, exp_d);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 12'h104, B = 12'h208, C = 12'h011, D = 12'h021, E = 12'h032;

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 0; snp_cmd = 0; snp_addr = '0; gnt_block = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ack && !bus_req && !bus_valid && !snp_abort, "R1 reset outputs",
        int'({cpu_ack, bus_req, bus_valid, snp_abort}), 0);

    // R1/R2: first read misses
    expect_bus(2'b01, A, 0, "R2");
    cpu_op(0, A, 0, 1, mem_of(A), 0, "R1 R2 read miss");
    // R3: read hit in shared
    cpu_op(0, A, 0, 1, mem_of(A), 1, "R3 shared hit");
    // R4: write to shared line
    expect_bus(2'b10, A, 0, "R4");
    cpu_op(1, A, 8'h11, 0, 0, 0, "R4 write shared");
    // R5: hits in exclusive
    cpu_op(0, A, 0, 1, 8'h11, 1, "R5 read excl");
    cpu_op(1, A, 8'h22, 0, 0, 1, "R5 write excl");
    cpu_op(0, A, 0, 1, 8'h22, 1, "R5 read back");
    // R6: dirty victim
    expect_bus(2'b11, A, 8'h22, "R6");
    expect_bus(2'b01, B, 0, "R6");
    cpu_op(0, B, 0, 1, mem_of(B), 0, "R6 victim write-back");
    // R7: clean victim
    expect_bus(2'b01, A, 0, "R7");
    cpu_op(0, A, 0, 1, mem_of(A), 0, "R7 shared replace");
    cpu_op(0, A, 0, 1, mem_of(A), 1, "R7 stays shared");
    // R8: snoop write miss invalidates shared copy
    snoop(2'b10, A, 0, 0, "R8 snoop wm shared");
    expect_bus(2'b01, A, 0, "R8");
    cpu_op(0, A, 0, 1, mem_of(A), 0, "R8 read after invalidate");
    // R9: snoop read miss on exclusive
    expect_bus(2'b10, C, 0, "R4");
    cpu_op(1, C, 8'h33, 0, 0, 0, "R4 write invalid");
    snoop(2'b01, C, 1, 8'h33, "R9 snoop rm excl");
    cpu_op(0, C, 0, 1, 8'h33, 1, "R9 data kept shared");
    expect_bus(2'b10, C, 0, "R9");
    cpu_op(1, C, 8'h44, 0, 0, 0, "R9 write needs wm");
    // R10: snoop write miss on exclusive
    snoop(2'b10, C, 1, 8'h44, "R10 snoop wm excl");
    expect_bus(2'b01, C, 0, "R10");
    cpu_op(0, C, 0, 1, mem_of(C), 0, "R10 read after invalidate");
    // R9: no abort for absent block or shared read miss
    snoop(2'b01, E, 0, 0, "R9 snoop absent");
    snoop(2'b01, C, 0, 0, "R9 snoop rm shared");
    cpu_op(0, C, 0, 1, mem_of(C), 1, "R9 shared survives");
    // R11: snoop while waiting for grant
    expect_bus(2'b10, D, 0, "R4");
    cpu_op(1, D, 8'h55, 0, 0, 0, "R4 write over shared");
    gnt_block = 1'b1;
    expect_bus(2'b01, C, 0, "R11");
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = C; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk(bus_req && !cpu_ack, "R12 req held while waiting", int'({bus_req, cpu_ack}), 2);
    snoop(2'b01, D, 1, 8'h55, "R11 snoop pending line");
    gnt_block = 1'b0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!cpu_ack && n < 100);
      chk(cpu_ack, "R11 ack", int'(cpu_ack), 1);
      chk(cpu_rdata == mem_of(C), "R11 read data", cpu_rdata, mem_of(C));
      chk(q_cmd.size() == 0, "R11 missing bus transaction", q_cmd.size(), 0);
      cpu_req = 1'b0;
    end
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule